// File: doc/BRIEF.md
# UART Transmit DMA Channel

This channel streams a block of bytes from memory into a UART transmitter without any per-byte processor work. Software programs a 16-bit source address and a byte count, sets the channel enable, and fires a write-one trigger. The channel then fetches one byte at a time over a request/grant memory port and hands each byte to the UART over a ready/valid port. It raises a completion flag and an optional interrupt once the last byte has been accepted.

The channel also watches the processor's own writes to the UART data register. If such a write arrives while a transfer is running, the write has lost its slot, and the channel records that in a sticky overwrite flag. Both flags are cleared by writing 0 to their bit. The two priority fields in the configuration register are held and driven out to the arbiter and the interrupt controller; they have no effect inside the channel.

Top module: `uart_tx_dma`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `busy` and `irq` are 0, and neither `mem_req` nor `tx_valid` is asserted.
- R2: Offset 0 (setup) holds the interrupt enable in bit 7, the interrupt priority in bits 3:2 and the bus priority in bits 1:0. Bits 6:4 read as 0. The two priority fields drive `irq_prio` and `bus_prio`.
- R3: At offset 1 (run control), bit 7 is the channel enable and bit 6 is the trigger. A transfer starts only when a single write sets both bits while the channel is idle. Any other write, or a write during a transfer, starts nothing. Bit 6 always reads 0.
- R4: With a count value N at offset 3, exactly N+1 bytes are sent: 0 sends 1 byte and 255 sends 256 bytes. The bytes match memory contents in address order.
- R5: The first fetch address is the 16-bit value {offset 5, offset 4} captured at the trigger. Each later fetch uses the previous address plus one, wrapping modulo 2^16. `mem_req` and `mem_addr` stay constant until `mem_gnt`.
- R6: A fetched byte stays on `tx_data` with `tx_valid` high until `tx_ready`. The next memory request is issued only after that acceptance, so `mem_req` and `tx_valid` are never high together.
- R7: The completion flag (offset 2, bit 0) is set in the clock edge where the final byte is accepted. `irq` equals that flag ANDed with the interrupt enable.
- R8: A pulse on `cpu_txd_wr` while `busy` is high sets the overwrite flag (offset 2, bit 2). The same pulse while idle leaves the flag unchanged.
- R9: Writing 0 to a status flag bit clears that flag. Writing 1 to it leaves the flag unchanged. A hardware set in the same cycle wins over the clear.
- R10: If the channel enable is 0 when a byte is accepted, the transfer ends right there. `busy` falls and the completion flag is not set.
- R11: The register offsets are 0 setup, 1 run control, 2 status, 3 count, 4 source address low byte, 5 source address high byte. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| cpu_txd_wr | input | 1 | Processor write to the UART data register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_gnt | input | 1 | Memory grant |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 8 | Memory read data |
| tx_valid | output | 1 | Byte offered to the UART |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART accepts the byte |
| irq | output | 1 | Completion interrupt |
| irq_prio | output | 2 | Stored interrupt priority |
| bus_prio | output | 2 | Stored bus-access priority |
| busy | output | 1 | Transfer in progress |

## Verification
Register read data and `busy`, `mem_req`, `tx_valid` follow state combinationally. Results that come from an edge therefore appear one edge after their cause:
- `busy` rises in the edge that takes the trigger write.
- The completion and overwrite flags, and with them `irq`, change in the edge where the last byte is accepted or where `cpu_txd_wr` is seen.
- After a fetch is granted, the byte appears on `tx_data` one edge after `mem_rvalid`.

The bench drives inputs just after each rising edge. Its behavioural model advances at each falling edge from the inputs and handshakes present at that moment. At the same falling edge it compares every output against the model state for the current cycle, so each expectation is read in the exact cycle the requirement says it is due.

// File: rtl/uart_dma_pkg.sv
// Shared definitions for the UART transmit DMA channel: register offsets,
// status bit positions and the sequencer state encoding.
package uart_dma_pkg;
    localparam int REG_AW      = 3;
    localparam int REG_DW      = 8;
    localparam int CNT_W       = 8;

    localparam logic [REG_AW-1:0] OFS_SETUP = 3'd0;
    localparam logic [REG_AW-1:0] OFS_RUN   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_STAT  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_COUNT = 3'd3;
    localparam logic [REG_AW-1:0] OFS_SRCL  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_SRCH  = 3'd5;

    localparam int BIT_IE      = 7;
    localparam int BIT_EN      = 7;
    localparam int BIT_TRIG    = 6;
    localparam int BIT_DONE    = 0;
    localparam int BIT_OVW     = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_RD   = 2'd2,
        SEQ_SEND = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_reg_bank.sv
// Register bank of the UART transmit DMA channel.
// Holds setup, run control, count and source address, plus the two sticky
// status flags. Assumes single-cycle register writes and combinational reads.
// A hardware set of a flag wins over a software clear in the same cycle.
module dma_reg_bank
    import uart_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [REG_DW-1:0]     reg_rdata,
    input  logic                  cpu_txd_wr,
    input  logic                  seq_busy,
    input  logic                  seq_done,
    output logic                  ch_en,
    output logic                  start,
    output logic [CNT_W-1:0]      byte_cnt,
    output logic [ADDR_W-1:0]     src_addr,
    output logic                  irq,
    output logic [1:0]            irq_prio,
    output logic [1:0]            bus_prio
);
    localparam int SRC_BYTES = 2;

    logic                        ie_q;
    logic                        en_q;
    logic [1:0]                  ip_q;
    logic [1:0]                  bp_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [SRC_BYTES*8-1:0]      src_q;
    logic                        done_q;
    logic                        ovw_q;
    logic                        wr_stat;

    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

    // Setup, run-control, count and source-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            en_q  <= 1'b0;
            ip_q  <= 2'b00;
            bp_q  <= 2'b00;
            cnt_q <= '0;
            src_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_SETUP: begin
                    ie_q <= reg_wdata[BIT_IE];
                    ip_q <= reg_wdata[3:2];
                    bp_q <= reg_wdata[1:0];
                end
                OFS_RUN:   en_q <= reg_wdata[BIT_EN];
                OFS_COUNT: cnt_q <= reg_wdata;
                OFS_SRCL:  src_q[7:0] <= reg_wdata;
                OFS_SRCH:  src_q[15:8] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Completion flag: set by the sequencer, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (seq_done)
            done_q <= 1'b1;
        else if (wr_stat && !reg_wdata[BIT_DONE])
            done_q <= 1'b0;
    end

    // Overwrite flag: set by a processor data write during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovw_q <= 1'b0;
        else if (cpu_txd_wr && seq_busy)
            ovw_q <= 1'b1;
        else if (wr_stat && !reg_wdata[BIT_OVW])
            ovw_q <= 1'b0;
    end

    // Trigger decode: enable and trigger in one write, channel idle.
    always_comb begin
        start = reg_wr && (reg_addr == OFS_RUN) && reg_wdata[BIT_EN]
                && reg_wdata[BIT_TRIG] && !seq_busy;
    end

    // Read multiplexer; unused and trigger bits read as zero.
    always_comb begin
        case (reg_addr)
            OFS_SETUP: reg_rdata = {ie_q, 3'b000, ip_q, bp_q};
            OFS_RUN:   reg_rdata = {en_q, 7'b0};
            OFS_STAT:  reg_rdata = {5'b0, ovw_q, 1'b0, done_q};
            OFS_COUNT: reg_rdata = cnt_q;
            OFS_SRCL:  reg_rdata = src_q[7:0];
            OFS_SRCH:  reg_rdata = src_q[15:8];
            default:   reg_rdata = '0;
        endcase
    end

    assign ch_en    = en_q;
    assign byte_cnt = cnt_q;
    assign src_addr = src_q[ADDR_W-1:0];
    assign irq      = done_q && ie_q;
    assign irq_prio = ip_q;
    assign bus_prio = bp_q;

    // R7: the completion flag only rises from a sequencer completion.
    p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(seq_done));

    // R8: the overwrite flag only rises from a data write during a transfer.
    p_ovw_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovw_q) |-> $past(cpu_txd_wr && seq_busy));

    // R9: a zero written to the completion bit with no set pending clears it.
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !reg_wdata[BIT_DONE] && !seq_done) |=> !done_q);
endmodule

// File: rtl/dma_xfer_seq.sv
// Byte sequencer of the UART transmit DMA channel.
// Fetches one byte per memory request, holds it for the UART until accepted,
// then either fetches the next, finishes, or aborts if the enable is low.
// Assumes mem_rvalid arrives after the grant, never in the grant cycle.
module dma_xfer_seq
    import uart_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  ch_en,
    input  logic [ADDR_W-1:0]     src_addr,
    input  logic [CNT_W-1:0]      byte_cnt,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  tx_valid,
    output logic [DATA_W-1:0]     tx_data,
    input  logic                  tx_ready,
    output logic                  busy,
    output logic                  done
);
    seq_state_e           state_q;
    logic [ADDR_W-1:0]    ptr_q;
    logic [CNT_W-1:0]     left_q;
    logic [DATA_W-1:0]    byte_q;
    logic                 accept;

    assign accept = (state_q == SEQ_SEND) && tx_ready;

    // Fetch / hold / hand-over state machine with pointer and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ptr_q   <= '0;
            left_q  <= '0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    ptr_q   <= src_addr;
                    left_q  <= byte_cnt;
                    state_q <= SEQ_REQ;
                end
                SEQ_REQ: if (mem_gnt) state_q <= SEQ_RD;
                SEQ_RD: if (mem_rvalid) begin
                    byte_q  <= mem_rdata;
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= SEQ_SEND;
                end
                SEQ_SEND: if (tx_ready) begin
                    if (!ch_en || left_q == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        left_q  <= left_q - 1'b1;
                        state_q <= SEQ_REQ;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output decode from the state.
    always_comb begin
        mem_req  = (state_q == SEQ_REQ);
        mem_addr = ptr_q;
        tx_valid = (state_q == SEQ_SEND);
        tx_data  = byte_q;
        busy     = (state_q != SEQ_IDLE);
        done     = accept && ch_en && (left_q == '0);
    end

    // R5: an ungranted request keeps its address.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R6: an unaccepted byte stays on the port.
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3: a transfer only begins from an accepted trigger.
    p_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: acceptance with the channel disabled ends the transfer.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !ch_en) |=> !busy);
endmodule

// File: rtl/uart_tx_dma.sv
// UART transmit DMA channel top level.
// Joins the register bank to the byte sequencer. Assumes a single clock and
// a synchronous active-low reset shared with the memory and UART sides.
module uart_tx_dma
    import uart_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [2:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  cpu_txd_wr,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  tx_valid,
    output logic [DATA_W-1:0]     tx_data,
    input  logic                  tx_ready,
    output logic                  irq,
    output logic [1:0]            irq_prio,
    output logic [1:0]            bus_prio,
    output logic                  busy
);
    logic                 ch_en;
    logic                 start;
    logic                 seq_done;
    logic [CNT_W-1:0]     byte_cnt;
    logic [ADDR_W-1:0]    src_addr;

    dma_reg_bank #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cpu_txd_wr (cpu_txd_wr),
        .seq_busy   (busy),
        .seq_done   (seq_done),
        .ch_en      (ch_en),
        .start      (start),
        .byte_cnt   (byte_cnt),
        .src_addr   (src_addr),
        .irq        (irq),
        .irq_prio   (irq_prio),
        .bus_prio   (bus_prio)
    );

    dma_xfer_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ch_en      (ch_en),
        .src_addr   (src_addr),
        .byte_cnt   (byte_cnt),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .busy       (busy),
        .done       (seq_done)
    );

    // R6: fetch and hand-over never overlap.
    p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));
endmodule

// File: tb/tb_uart_tx_dma.sv
`timescale 1ns/1ps
module tb_uart_tx_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd2;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cpu_txd_wr = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;
    logic [1:0]  irq_prio;
    logic [1:0]  bus_prio;
    logic        busy;

    always #2.5 clk = ~clk;

    uart_tx_dma dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_txd_wr(cpu_txd_wr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq), .irq_prio(irq_prio),
        .bus_prio(bus_prio), .busy(busy)
    );

    int n_vec = 0;
    int n_bad = 0;
    int n_hs  = 0;
    bit stall = 1'b0;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        m_ie, m_en, m_done, m_ovw, m_busy;
    logic [1:0]  m_ip, m_bp;
    logic [7:0]  m_cnt;
    logic [15:0] m_src, m_ptr;
    logic [7:0]  q[$];
    bit          prev_stall = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_ie, 3'b000, m_ip, m_bp};
            3'd1: return {m_en, 7'b0};
            3'd2: return {5'b0, m_ovw, 1'b0, m_done};
            3'd3: return m_cnt;
            3'd4: return m_src[7:0];
            3'd5: return m_src[15:8];
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_en = 0; m_done = 0; m_ovw = 0; m_busy = 0;
            m_ip = 0; m_bp = 0; m_cnt = 0; m_src = 0; m_ptr = 0;
            q.delete();
            prev_stall = 0;
        end else begin
            automatic bit hs = tx_valid && tx_ready;
            automatic bit busy_old = m_busy;
            automatic bit set_done = 0;
            automatic bit clr_done = 0;
            automatic bit clr_ovw = 0;
            // compare current outputs
            chk(busy == m_busy, "R3 busy", busy, m_busy);
            chk(irq == (m_done && m_ie), "R7 irq", irq, m_done && m_ie);
            chk({irq_prio, bus_prio} == {m_ip, m_bp}, "R2 prio",
                {irq_prio, bus_prio}, {m_ip, m_bp});
            chk(reg_rdata == m_read(reg_addr), "R11 read", reg_rdata, m_read(reg_addr));
            chk(!(mem_req && tx_valid), "R6 overlap", {mem_req, tx_valid}, 0);
            if (mem_req) chk(mem_addr == m_ptr, "R5 address", mem_addr, m_ptr);
            if (hs) chk(q.size() > 0 && tx_data == q[0], "R4 data", tx_data,
                        (q.size() > 0) ? q[0] : 8'hxx);
            if (prev_stall) chk(tx_valid && tx_data == prev_data, "R6 hold",
                                {tx_valid, tx_data}, {1'b1, prev_data});
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            // advance the model to the next edge
            if (mem_req && mem_gnt) m_ptr = m_ptr + 16'd1;
            if (hs && m_busy) begin
                n_hs++;
                void'(q.pop_front());
                if (!m_en) begin
                    m_busy = 0;
                    q.delete();
                end else if (q.size() == 0) begin
                    m_busy = 0;
                    set_done = 1;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_ie = reg_wdata[7]; m_ip = reg_wdata[3:2]; m_bp = reg_wdata[1:0]; end
                    3'd1: begin
                        if (reg_wdata[7] && reg_wdata[6] && !busy_old) begin
                            m_busy = 1;
                            m_ptr  = m_src;
                            q.delete();
                            for (int i = 0; i <= int'(m_cnt); i++)
                                q.push_back(mem_fn(m_src + 16'(i)));
                        end
                        m_en = reg_wdata[7];
                    end
                    3'd2: begin clr_done = !reg_wdata[0]; clr_ovw = !reg_wdata[2]; end
                    3'd3: m_cnt = reg_wdata;
                    3'd4: m_src[7:0] = reg_wdata;
                    3'd5: m_src[15:8] = reg_wdata;
                    default: ;
                endcase
            end
            if (set_done) m_done = 1; else if (clr_done) m_done = 0;
            if (cpu_txd_wr && busy_old) m_ovw = 1; else if (clr_ovw) m_ovw = 0;
        end
    end

    // ---------------- memory and UART responders ----------------
    logic [15:0] lf = 16'hACE1;
    logic [15:0] lat_addr = 16'h0000;
    bit          pend = 0;
    int          dly = 0;

    always @(posedge clk) begin
        #1;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        mem_gnt = 0;
        mem_rvalid = 0;
        if (pend) begin
            mem_rvalid = 1;
            mem_rdata  = mem_fn(lat_addr);
            pend = 0;
        end else if (mem_req) begin
            if (dly == 0) begin
                mem_gnt = 1;
                lat_addr = mem_addr;
                pend = 1;
                dly = int'(lf[5:4]);
            end else begin
                dly--;
            end
        end
        tx_ready = stall ? 1'b0 : (lf[0] | lf[3]);
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_addr = 3'd2;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        for (int a = 0; a < 6; a++) expect_rd(3'(a), 8'h00, "R1 reset value");
        chk(!busy && !irq && !mem_req && !tx_valid, "R1 idle outputs",
            {busy, irq, mem_req, tx_valid}, 0);
        // R2: setup register layout
        wr(3'd0, 8'hFF);
        expect_rd(3'd0, 8'h8F, "R2 setup readback");
        chk(irq_prio == 2'd3 && bus_prio == 2'd3, "R2 priority outputs", {irq_prio, bus_prio}, 4'hF);
        wr(3'd0, 8'h86);
        chk(irq_prio == 2'd1 && bus_prio == 2'd2, "R2 priority fields", {irq_prio, bus_prio}, 4'h6);
        // R3: trigger without enable is ignored
        wr(3'd3, 8'd0);
        wr(3'd4, 8'h34);
        wr(3'd5, 8'h12);
        expect_rd(3'd5, 8'h12, "R11 source high offset");
        wr(3'd1, 8'h40);
        chk(!busy, "R3 trigger without enable", busy, 0);
        // R4 single byte, R7 completion and irq
        n_hs = 0;
        wr(3'd1, 8'hC0);
        chk(busy, "R3 trigger accepted", busy, 1);
        expect_rd(3'd1, 8'h80, "R3 trigger reads zero");
        wait_idle();
        chk(n_hs == 1, "R4 count 0 sends one byte", n_hs, 1);
        expect_rd(3'd2, 8'h01, "R7 completion flag");
        chk(irq, "R7 irq asserted", irq, 1);
        // R9: writing 1 keeps, writing 0 clears
        wr(3'd2, 8'h05);
        expect_rd(3'd2, 8'h01, "R9 write one keeps flag");
        wr(3'd2, 8'h00);
        expect_rd(3'd2, 8'h00, "R9 write zero clears flag");
        chk(!irq, "R9 irq drops", irq, 0);
        // R5 page crossing, R8 overwrite, R3 retrigger while busy
        n_hs = 0;
        wr(3'd3, 8'd4);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'h00);
        wr(3'd1, 8'hC0);
        @(posedge clk); #1 cpu_txd_wr = 1;
        @(posedge clk); #1 cpu_txd_wr = 0;
        wr(3'd1, 8'hC0);
        wait_idle();
        chk(n_hs == 5, "R3 retrigger ignored, R4 five bytes", n_hs, 5);
        expect_rd(3'd2, 8'h05, "R8 overwrite flag set");
        wr(3'd2, 8'h01);
        expect_rd(3'd2, 8'h01, "R9 overwrite cleared alone");
        wr(3'd2, 8'h00);
        // R8: data write while idle has no effect
        @(posedge clk); #1 cpu_txd_wr = 1;
        @(posedge clk); #1 cpu_txd_wr = 0;
        expect_rd(3'd2, 8'h00, "R8 idle write ignored");
        // R4: 256 bytes with address wrap; R6 with long stall
        n_hs = 0;
        wr(3'd3, 8'd255);
        wr(3'd4, 8'hF0);
        wr(3'd5, 8'hFF);
        wr(3'd1, 8'hC0);
        repeat (10) @(posedge clk);
        stall = 1;
        repeat (12) @(posedge clk);
        stall = 0;
        wait_idle();
        chk(n_hs == 256, "R4 count 255 sends 256 bytes", n_hs, 256);
        expect_rd(3'd2, 8'h01, "R7 flag after long run");
        wr(3'd2, 8'h00);
        // R10: abort by clearing enable
        n_hs = 0;
        wr(3'd3, 8'd40);
        wr(3'd1, 8'hC0);
        repeat (20) @(posedge clk);
        wr(3'd1, 8'h00);
        wait_idle();
        chk(n_hs > 0 && n_hs < 41, "R10 abort stops early", n_hs, 40);
        expect_rd(3'd2, 8'h00, "R10 no completion flag");
        chk(!busy, "R10 idle after abort", busy, 0);
        expect_rd(3'd7, 8'h00, "R11 unused offset");
        summary();
        $finish;
    end
endmodule